// File: doc/BRIEF.md
# Count-Committed Transmit Byte Buffer

This block is the transmit-side storage of a high-rate serial port. A host stages outgoing bytes by writing into a 1024-byte memory-mapped window. Window byte k lands in the ring buffer at position write pointer + k, modulo the depth. Staged bytes stay hidden from the serializer until the host writes a byte count to the control register. That commit advances the write pointer and the fill count together. The serializer drains committed bytes one at a time through a pop port.

The write pointer does not have to sit on a 32-bit boundary. Window writes therefore honour byte strobes. A single read of the control register returns both the write pointer and the fill count, so software can work out the free space and the next staging position from one access.

The block raises a space-available request while the fill count is at or below a programmable trigger level and the request is enabled. It reports empty only when no committed byte is left.

Top module: `tx_commit_buf`

## Requirements
- R1: After reset the write pointer and the fill count are 0, `empty_o` is 1 and `pop_valid_o` is 0.
- R2: A read at byte address 0x804 returns the write pointer in bits [9:0] and the fill count in bits [25:16]; all other bits are 0. A read at any other address returns 0.
- R3: A write to byte address 0x804 commits N = wdata[9:0] bytes whatever the byte strobes; bits [31:10] are ignored. The fill count grows by N and the write pointer advances by N modulo 1024, both visible one cycle after the write.
- R4: The fill count never exceeds 1020. A commit larger than 1020 minus the fill count is clipped to that free space.
- R5: Window writes (byte addresses 0x400 to 0x7FF) change neither the fill count nor the write pointer, and they make no byte visible at the pop port.
- R6: A window write at word address w with strobe bit l set stores wdata[8l+7:8l] at ring position (write pointer + 4w + l) mod 1024. Bytes whose strobe is clear keep their old content.
- R7: `pop_data_o` shows the oldest committed byte, at ring position (write pointer - fill count) mod 1024. Asserting `pop_i` while the fill count is nonzero removes that byte. A pop while the buffer is empty has no effect.
- R8: `empty_o` is 1 exactly when the fill count is 0, and `pop_valid_o` is its inverse.
- R9: `space_req_o` is 1 exactly when `space_en_i` is 1 and the fill count is at most 4 << `trig_code_i`. For example, code 5 gives 128 and code 0 gives 4.
- R10: A commit and a pop in the same cycle both take effect. The clip uses the fill count before the pop, and the new fill is old fill + clipped N - 1.
- R11: Host writes to any address outside the window and the control register change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host write strobe |
| reg_addr_i | input | 12 | Host byte address for writes and reads |
| reg_be_i | input | 4 | Byte strobes for window writes |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| trig_code_i | input | 3 | Space-request trigger level code |
| space_en_i | input | 1 | Space-request enable |
| pop_i | input | 1 | Serializer takes the oldest byte |
| pop_data_o | output | 8 | Oldest committed byte |
| pop_valid_o | output | 1 | At least one committed byte is present |
| space_req_o | output | 1 | Space-available request |
| empty_o | output | 1 | No committed byte left |

## Verification
Staging and commit are tried at all four write-pointer alignments with every one of the fifteen nonzero strobe patterns. This separates correct per-lane placement from lane swaps and from stale bytes being overwritten. Multi-word staging, commits with junk in the upper bits and writes to stray addresses tell a correct decode apart from one that reads extra count bits or matches too loosely. A full-window fill committed with an oversized count, then drained byte by byte across the ring wrap while all eight trigger codes are swept at every fill level, separates the clip, the threshold comparison and the read-pointer arithmetic. Same-cycle commit and pop, at both full and partly filled levels, shows whether the clip uses the fill count from before or after the pop.

// File: rtl/tx_buf_pkg.sv
package tx_buf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = BYTE_W * LANES;
  // readback field position of the fill count, decoded by software
  localparam int unsigned FILL_LSB = 16;
endpackage

// File: rtl/tx_buf_decode.sv
module tx_buf_decode
  import tx_buf_pkg::*;
#(
  parameter int unsigned PTR_W     = 10,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 12'h400,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h804
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LANES-1:0]  win_we_o,
  output logic [PTR_W-1:0]  win_off_o,
  output logic              commit_o,
  output logic [PTR_W-1:0]  commit_n_o,
  output logic              rd_ctrl_o
);
  logic win_hit, ctrl_sel;
  logic unused_bits;

  assign win_hit   = addr_i[ADDR_W-1:PTR_W] == WIN_BASE[ADDR_W-1:PTR_W];
  assign ctrl_sel  = addr_i[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2];
  assign win_we_o  = (we_i && win_hit) ? be_i : '0;
  assign win_off_o = {addr_i[PTR_W-1:2], 2'b00};
  assign commit_o  = we_i && ctrl_sel;
  assign commit_n_o = wdata_i[PTR_W-1:0];
  assign rd_ctrl_o = ctrl_sel;
  assign unused_bits = ^{wdata_i[DATA_W-1:PTR_W], addr_i[1:0]};
endmodule

// File: rtl/tx_buf_ram.sv
module tx_buf_ram
  import tx_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [PTR_W-1:0]  base_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  lane_idx [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_idx[g] = base_i + PTR_W'(g);
  end

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (we_i[l]) mem[lane_idx[l]] <= wdata_i[l*BYTE_W +: BYTE_W];
    end
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/tx_buf_ctrl.sv
module tx_buf_ctrl #(
  parameter int unsigned PTR_W      = 10,
  parameter int unsigned MAX_FILL   = 1020,
  parameter int unsigned TRIG_W     = 3,
  parameter int unsigned TRIG_SHIFT = 2,
  localparam int unsigned CNT_W = $clog2(MAX_FILL + 1),
  localparam int unsigned SUM_W = ((PTR_W > CNT_W) ? PTR_W : CNT_W) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [PTR_W-1:0]  commit_n_i,
  input  logic              pop_i,
  input  logic [TRIG_W-1:0] trig_code_i,
  input  logic              space_en_i,
  output logic [PTR_W-1:0]  wptr_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              empty_o,
  output logic              space_req_o
);
  logic [PTR_W-1:0] wptr_q;
  logic [CNT_W-1:0] fill_q;
  logic [SUM_W-1:0] n_ext, free_ext, n_eff, fill_nxt, thr;
  logic             pop_ok;

  assign n_ext    = SUM_W'(commit_n_i);
  assign free_ext = SUM_W'(MAX_FILL) - SUM_W'(fill_q);
  assign n_eff    = !commit_i ? '0 : ((n_ext > free_ext) ? free_ext : n_ext);
  assign pop_ok   = pop_i && (fill_q != '0);
  assign fill_nxt = SUM_W'(fill_q) + n_eff - SUM_W'(pop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_q + n_eff[PTR_W-1:0];
      fill_q <= fill_nxt[CNT_W-1:0];
    end
  end

  assign thr         = SUM_W'(1) << (TRIG_SHIFT + 32'(trig_code_i));
  assign space_req_o = space_en_i && (SUM_W'(fill_q) <= thr);
  assign empty_o     = fill_q == '0;
  assign wptr_o      = wptr_q;
  assign rptr_o      = wptr_q - PTR_W'(fill_q);
  assign fill_o      = fill_q;
endmodule

// File: rtl/tx_commit_buf.sv
module tx_commit_buf
  import tx_buf_pkg::*;
#(
  parameter int unsigned DEPTH      = 1024,
  parameter int unsigned MAX_FILL   = 1020,
  parameter int unsigned TRIG_W     = 3,
  parameter int unsigned TRIG_SHIFT = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 12'h400,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h804,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(MAX_FILL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [3:0]        reg_be_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [2:0]        trig_code_i,
  input  logic              space_en_i,
  input  logic              pop_i,
  output logic [7:0]        pop_data_o,
  output logic              pop_valid_o,
  output logic              space_req_o,
  output logic              empty_o
);
  logic [LANES-1:0] win_we;
  logic [PTR_W-1:0] win_off, commit_n, wptr, rptr;
  logic [CNT_W-1:0] fill;
  logic             commit, rd_ctrl;
  logic [31:0]      ctrl_word;

  tx_buf_decode #(
    .PTR_W(PTR_W), .WIN_BASE(WIN_BASE), .CTRL_ADDR(CTRL_ADDR)
  ) u_dec (
    .we_i(reg_we_i), .addr_i(reg_addr_i), .be_i(reg_be_i),
    .wdata_i(reg_wdata_i), .win_we_o(win_we), .win_off_o(win_off),
    .commit_o(commit), .commit_n_o(commit_n), .rd_ctrl_o(rd_ctrl)
  );

  tx_buf_ctrl #(
    .PTR_W(PTR_W), .MAX_FILL(MAX_FILL), .TRIG_W(TRIG_W), .TRIG_SHIFT(TRIG_SHIFT)
  ) u_ctrl (
    .clk_i, .rst_ni, .commit_i(commit), .commit_n_i(commit_n), .pop_i,
    .trig_code_i, .space_en_i, .wptr_o(wptr), .rptr_o(rptr),
    .fill_o(fill), .empty_o, .space_req_o
  );

  tx_buf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i, .we_i(win_we), .base_i(wptr + win_off), .wdata_i(reg_wdata_i),
    .rd_idx_i(rptr), .rd_data_o(pop_data_o)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[PTR_W-1:0] = wptr;
    ctrl_word[FILL_LSB +: CNT_W] = fill;
  end

  assign reg_rdata_o = rd_ctrl ? ctrl_word : '0;
  assign pop_valid_o = !empty_o;
endmodule

// File: rtl/tx_commit_buf_chk.sv
module tx_commit_buf_chk #(
  parameter int unsigned PTR_W = 10,
  parameter int unsigned CNT_W = 10,
  parameter int unsigned MAX_FILL = 1020,
  parameter logic [11:0] CTRL_ADDR = 12'h804
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [11:0]      reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             pop_i,
  input logic             space_en_i,
  input logic             space_req_o,
  input logic             pop_valid_o,
  input logic             empty_o,
  input logic [PTR_W-1:0] wptr_i,
  input logic [CNT_W-1:0] fill_i
);
  logic is_ctrl;
  assign is_ctrl = reg_addr_i[11:2] == CTRL_ADDR[11:2];

  // R4
  fill_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill_i) <= int'(MAX_FILL));

  // R3
  commit_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && is_ctrl && !pop_i &&
     int'(reg_wdata_i[PTR_W-1:0]) <= int'(MAX_FILL) - int'(fill_i))
    |=> int'(fill_i) == int'($past(fill_i)) + int'($past(reg_wdata_i[PTR_W-1:0])));

  // R5
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !is_ctrl && !pop_i) |=> ($stable(fill_i) && $stable(wptr_i)));

  // R7
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && pop_valid_o && !(reg_we_i && is_ctrl))
    |=> int'(fill_i) == int'($past(fill_i)) - 1);

  // R9
  space_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !space_en_i |-> !space_req_o);

  // R8
  empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({empty_o, pop_valid_o}) && (empty_o || pop_valid_o));
endmodule

bind tx_commit_buf tx_commit_buf_chk #(
  .PTR_W(PTR_W), .CNT_W(CNT_W), .MAX_FILL(MAX_FILL), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .pop_i(pop_i), .space_en_i(space_en_i),
  .space_req_o(space_req_o), .pop_valid_o(pop_valid_o), .empty_o(empty_o),
  .wptr_i(wptr), .fill_i(fill)
);

// File: tb/sim_tx_commit_buf.sv
`timescale 1ns/1ps
module sim_tx_commit_buf;
  localparam int DEPTH = 1024;
  localparam int MAXF  = 1020;
  localparam logic [11:0] CTRL = 12'h804;

  logic clk = 0, rst_ni = 0;
  logic reg_we = 0, pop = 0, space_en = 1;
  logic [11:0] reg_addr = CTRL;
  logic [3:0]  reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [2:0]  trig = 3'd5;
  logic [7:0]  pop_data;
  logic pop_valid, space_req, empty;

  int checks = 0, errs = 0, cycles = 0;
  int m_wptr = 0, m_fill = 0;
  logic [7:0] m_mem [DEPTH];
  bit m_known [DEPTH];

  always #4 clk = ~clk;

  tx_commit_buf u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_be_i(reg_be), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .trig_code_i(trig), .space_en_i(space_en), .pop_i(pop),
    .pop_data_o(pop_data), .pop_valid_o(pop_valid), .space_req_o(space_req),
    .empty_o(empty)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [3:0] be, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_addr = CTRL; reg_be = 0;
  endtask

  task automatic win_wr(int w, logic [3:0] be, logic [31:0] d);
    for (int l = 0; l < 4; l++) if (be[l]) begin
      m_mem[(m_wptr + 4*w + l) % DEPTH] = d[8*l +: 8];
      m_known[(m_wptr + 4*w + l) % DEPTH] = 1;
    end
    bus_wr(12'h400 + 12'(4*w), be, d);
  endtask

  function automatic int clip(int d);
    int n = d & 1023;
    return (n > MAXF - m_fill) ? MAXF - m_fill : n;
  endfunction

  task automatic commit(logic [31:0] d);
    int n = clip(int'(d));
    bus_wr(CTRL, 4'h0, d);
    m_wptr = (m_wptr + n) % DEPTH; m_fill += n;
  endtask

  task automatic rd_ctrl(string tag);
    reg_addr = CTRL; #1;
    chk({tag, " R2 wptr"}, int'(reg_rdata[9:0]), m_wptr);
    chk({tag, " R2 fill"}, int'(reg_rdata[25:16]), m_fill);
    chk({tag, " R2 zero bits"}, int'({reg_rdata[31:26], reg_rdata[15:10]}), 0);
    chk({tag, " R8 empty"}, int'(empty), int'(m_fill == 0));
    chk({tag, " R8 valid"}, int'(pop_valid), int'(m_fill != 0));
  endtask

  task automatic check_head(string tag);
    int r = (m_wptr - m_fill + DEPTH) % DEPTH;
    if (m_fill > 0 && m_known[r]) chk({tag, " R7 R6 data"}, int'(pop_data), int'(m_mem[r]));
  endtask

  task automatic pop_one(string tag);
    check_head(tag);
    pop = 1; @(negedge clk); pop = 0;
    if (m_fill > 0) m_fill--;
  endtask

  task automatic commit_pop(logic [31:0] d);
    int n;
    check_head("R10 head");
    n = clip(int'(d));
    reg_we = 1; reg_addr = CTRL; reg_wdata = d; pop = 1;
    @(negedge clk);
    reg_we = 0; pop = 0;
    m_wptr = (m_wptr + n) % DEPTH;
    m_fill = m_fill + n - ((m_fill > 0) ? 1 : 0);
  endtask

  task automatic space_sweep(string tag);
    for (int c = 0; c < 8; c++) begin
      trig = 3'(c); #1;
      chk({tag, " R9 space_req"}, int'(space_req), int'(space_en && m_fill <= (4 << c)));
    end
    trig = 3'd5;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errs++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errs);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    rd_ctrl("R1 reset");
    space_sweep("R1");

    // R5: staged bytes invisible
    win_wr(0, 4'hF, 32'h44332211);
    win_wr(1, 4'h3, 32'h00006655);
    rd_ctrl("R5 staged");

    // R3: commit three
    commit(3);
    rd_ctrl("R3 commit3");
    for (int i = 0; i < 3; i++) pop_one("R7 drain3");
    rd_ctrl("R7 after drain");

    // R6: alignment x strobe sweep
    for (int a = 0; a < 4; a++) begin
      for (int be = 1; be < 16; be++) begin
        win_wr(0, 4'hF, 32'hA0B0C0D0 ^ (a * 32'h01010101));
        win_wr(0, 4'(be), {8'(be), 8'(a), 8'(be + 16), 8'(a + 32)});
        commit(4);
        rd_ctrl("R6 align");
        for (int i = 0; i < 4; i++) pop_one("R6 align");
      end
      win_wr(0, 4'h1, 32'h5A);
      commit(1);
      pop_one("R6 step");
    end

    // R6: multi-word staging
    win_wr(0, 4'hF, 32'h03020100);
    win_wr(1, 4'hF, 32'h07060504);
    win_wr(2, 4'hF, 32'h0B0A0908);
    commit(10);
    rd_ctrl("R6 multi");
    for (int i = 0; i < 10; i++) pop_one("R6 multi");

    // R3: upper bits ignored
    win_wr(0, 4'hF, 32'hDEADBEEF);
    commit(32'hABCD_FC02);
    rd_ctrl("R3 high bits");
    pop_one("R3 high"); pop_one("R3 high");

    // R11: stray addresses
    bus_wr(12'h000, 4'hF, 32'h5);
    bus_wr(12'h808, 4'hF, 32'h7);
    bus_wr(12'h800, 4'hF, 32'h9);
    bus_wr(12'hC04, 4'hF, 32'h3);
    rd_ctrl("R11 stray");
    reg_addr = 12'h808; #1;
    chk("R2 other addr read", int'(reg_rdata), 0);

    // R7: pop when empty
    pop_one("R7 empty pop");
    rd_ctrl("R7 empty pop");

    // R4: fill whole window, oversized commit
    for (int w = 0; w < 256; w++) win_wr(w, 4'hF, 32'(w) * 32'h01030507 + 32'h11);
    commit(1023);
    rd_ctrl("R4 clip");
    commit(5);
    rd_ctrl("R4 full");
    space_sweep("R4 full");

    // R10: commit and pop together when full
    commit_pop(3);
    rd_ctrl("R10 full");

    // R7/R9: drain with threshold sweep
    while (m_fill > 0) begin
      space_sweep("R9 drain");
      pop_one("R7 drain");
    end
    rd_ctrl("R7 drained");

    // R10: partial
    win_wr(0, 4'hF, 32'h87654321);
    win_wr(1, 4'hF, 32'h0FEDCBA9);
    commit(2);
    commit_pop(4);
    rd_ctrl("R10 partial");
    while (m_fill > 0) pop_one("R10 drain");

    // R9: disabled
    space_en = 0;
    space_sweep("R9 disabled");

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule